// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a 32-bit processor core from ordinary execution into a trap or interrupt handler. Each cycle that it is idle, it looks at four one-cycle event requests: a software break, a non-maskable interrupt, a bus fault, and an external interrupt that comes with its own vector number. It decides which of them, if any, is taken. The enable flags in the live status word gate the two interrupt kinds.

On the edge that accepts an event, the block does the bookkeeping for the entry. It writes the return address, which is backed up when a delay slot was pending. It writes the exception status word and the rotated status word. It swaps the stack pointers when the core was in user mode. It then reads the handler address from a vector table through a single-word memory read port and presents that word as the new PC, with a one-cycle load pulse. The core holds its normal flow for as long as `busy` is high.

Top module: `exc_entry_seq`

## Requirements
- R1: An external interrupt request (`evIrq`) is accepted only when status bit 4 (interrupt enable) of `ccsIn` is 1 and `irqLock` is 0. Otherwise it is dropped and `busy` stays 0.
- R2: A non-maskable request (`evNmi`) is accepted only when its enable flag is 1. That flag is `ccsIn` bit 9 when `archVer` < 32 and bit 30 otherwise.
- R3: When several accepted requests arrive in the same idle cycle, exactly one is taken, in the order non-maskable, bus fault, break, external interrupt.
- R4: A non-maskable entry uses vector 0 and writes its return address to `nrpOut`, leaving `erpOut` unchanged. Break, bus fault and external interrupt entries use `trapVec`, `faultVec` and `irqVec` respectively and write `erpOut`, leaving `nrpOut` unchanged.
- R5: `exsOut` is written with the 8-bit vector in bits 15:8 and zeros in all other bits.
- R6: The saved return address is `pcIn - dslotCnt`. `dslotClr` is 1 for the single cycle after acceptance exactly when `dslotCnt` was nonzero.
- R7: When `ccsIn` bit 8 (user mode) is 1, `uspOut` takes `spIn` and `spOut` takes `kspIn`. When it is 0, `spOut` takes `spIn` and `uspOut` keeps its value.
- R8: `ccsOut` takes the status word with bits 31:30 kept, bits 19:0 moved to bits 29:10 and bits 9:0 zero. For a non-maskable entry, the enable flag of R2 is cleared before this rotation.
- R9: After acceptance, `memReq` is held high with `memAddr = ebpIn + 4*vector` until `memRvalid`. On the cycle after `memRvalid`, `pcOut` equals the `memRdata` word and `pcLoad` is high for exactly one cycle; then `busy` returns to 0.
- R10: Requests arriving while `busy` is 1 are ignored.
- R11: A bus fault request during a bus fault entry sets `fatalErr`. It stays 1, with `busy` 1 and `memReq` 0, until reset.
- R12: After reset, all register outputs and `busy`, `memReq`, `pcLoad`, `dslotClr` and `fatalErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evBreak | input | 1 | Software break request (one cycle) |
| evNmi | input | 1 | Non-maskable interrupt request |
| evBusFault | input | 1 | Bus fault request |
| evIrq | input | 1 | External interrupt request |
| irqVec | input | 8 | Vector from the interrupt controller |
| trapVec | input | 8 | Vector for a break |
| faultVec | input | 8 | Vector for a bus fault |
| irqLock | input | 1 | External interrupt lock |
| pcIn | input | 32 | Current PC |
| dslotCnt | input | 2 | Pending delay-slot count, 0 when none |
| ccsIn | input | 32 | Current status word |
| archVer | input | 8 | Architecture version value |
| spIn | input | 32 | Current stack pointer |
| kspIn | input | 32 | Kernel stack pointer |
| ebpIn | input | 32 | Vector table base |
| memRdata | input | 32 | Read data |
| memRvalid | input | 1 | Read data valid |
| memReq | output | 1 | Read request |
| memAddr | output | 32 | Read address |
| busy | output | 1 | Entry in progress |
| pcLoad | output | 1 | New PC valid pulse |
| pcOut | output | 32 | Handler PC |
| erpOut | output | 32 | Exception return address |
| nrpOut | output | 32 | Non-maskable return address |
| uspOut | output | 32 | Saved user stack pointer |
| spOut | output | 32 | Stack pointer after entry |
| ccsOut | output | 32 | Status word after entry |
| exsOut | output | 32 | Exception status word |
| dslotClr | output | 1 | Delay-slot clear pulse |
| fatalErr | output | 1 | Sticky recursive bus fault flag |

## Verification
The hardest state to reach is the recursive bus fault. A second fault must land inside the short window of an entry that is itself a bus fault. The bench stretches that window by making the memory responder slow, then pulses the fault input again mid-fetch. A sweep crosses every event kind with both user-mode values, all delay-slot counts and both version ranges, and a separate sweep walks all 256 external interrupt vectors with varying read latency.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN      = 32;
  localparam int VEC_W     = 8;
  localparam int DS_W      = 2;
  localparam int VER_W     = 8;
  localparam int I_BIT     = 4;
  localparam int U_BIT     = 8;
  localparam int M_BIT_OLD = 9;
  localparam int M_BIT_NEW = 30;
  localparam int VER_SPLIT = 32;
  localparam int KEEP_HI   = 2;
  localparam int ROT_SHIFT = 10;
  localparam int MOVE_W    = XLEN - KEEP_HI - ROT_SHIFT;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_JUMP, ST_HALT} seqState_t;
  typedef enum logic [2:0] {EV_NONE, EV_NMI, EV_BUSF, EV_BRK, EV_IRQ} evKind_t;

  typedef struct packed {
    logic    capture;
    evKind_t kind;
    logic    loadPc;
  } seqStrobe_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evBreak,
  input  logic       evNmi,
  input  logic       evBusFault,
  input  logic       evIrq,
  input  logic       irqLock,
  input  logic       iFlag,
  input  logic       mFlag,
  input  logic       memRvalid,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       memReq,
  output logic       pcLoad,
  output logic       fatalErr
);
  seqState_t state;
  evKind_t   pick;
  evKind_t   curKind;
  logic      recursive;

  always_comb begin
    pick = EV_NONE;
    if (state == ST_IDLE) begin
      if (evNmi && mFlag)                   pick = EV_NMI;
      else if (evBusFault)                  pick = EV_BUSF;
      else if (evBreak)                     pick = EV_BRK;
      else if (evIrq && iFlag && !irqLock)  pick = EV_IRQ;
    end
  end

  assign recursive = evBusFault && (curKind == EV_BUSF) &&
                     ((state == ST_FETCH) || (state == ST_JUMP));

  always_comb begin
    strobe.capture = (pick != EV_NONE);
    strobe.kind    = pick;
    strobe.loadPc  = (state == ST_FETCH) && memRvalid && !recursive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curKind  <= EV_NONE;
      fatalErr <= 1'b0;
    end else if (recursive) begin
      state    <= ST_HALT;
      fatalErr <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE:  if (pick != EV_NONE) begin
                    state   <= ST_FETCH;
                    curKind <= pick;
                  end
        ST_FETCH: if (memRvalid) state <= ST_JUMP;
        ST_JUMP:  begin
                    state   <= ST_IDLE;
                    curKind <= EV_NONE;
                  end
        default:  state <= ST_HALT;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_FETCH);
  assign pcLoad = (state == ST_JUMP);
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic [VEC_W-1:0]  trapVec,
  input  logic [VEC_W-1:0]  faultVec,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [DS_W-1:0]   dslotCnt,
  input  logic [XLEN-1:0]   ccsIn,
  input  logic [VER_W-1:0]  archVer,
  input  logic [XLEN-1:0]   spIn,
  input  logic [XLEN-1:0]   kspIn,
  input  logic [XLEN-1:0]   ebpIn,
  input  logic [XLEN-1:0]   memRdata,
  output logic              iFlag,
  output logic              mFlag,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   erpOut,
  output logic [XLEN-1:0]   nrpOut,
  output logic [XLEN-1:0]   uspOut,
  output logic [XLEN-1:0]   spOut,
  output logic [XLEN-1:0]   ccsOut,
  output logic [XLEN-1:0]   exsOut,
  output logic              dslotClr
);
  localparam int EXS_LO = VEC_W;
  localparam int EXS_HI = XLEN - 2 * VEC_W;

  logic [VEC_W-1:0] vecSel, vecReg;
  logic [XLEN-1:0]  baseReg, retAddr, ccsMasked, ccsRot, mMask;
  logic             oldArch, userMode, isNmi;

  assign oldArch  = (archVer < VER_W'(VER_SPLIT));
  assign iFlag    = ccsIn[I_BIT];
  assign mFlag    = oldArch ? ccsIn[M_BIT_OLD] : ccsIn[M_BIT_NEW];
  assign userMode = ccsIn[U_BIT];
  assign isNmi    = (strobe.kind == EV_NMI);
  assign mMask    = oldArch ? (XLEN'(1) << M_BIT_OLD) : (XLEN'(1) << M_BIT_NEW);

  always_comb begin
    unique case (strobe.kind)
      EV_BRK:  vecSel = trapVec;
      EV_BUSF: vecSel = faultVec;
      EV_IRQ:  vecSel = irqVec;
      default: vecSel = '0;
    endcase
  end

  assign retAddr   = pcIn - XLEN'(dslotCnt);
  assign ccsMasked = isNmi ? (ccsIn & ~mMask) : ccsIn;
  assign ccsRot    = {ccsMasked[XLEN-1 -: KEEP_HI], ccsMasked[MOVE_W-1:0], {ROT_SHIFT{1'b0}}};
  assign memAddr   = baseReg + {{(XLEN-VEC_W-2){1'b0}}, vecReg, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg   <= '0;
      baseReg  <= '0;
      pcOut    <= '0;
      erpOut   <= '0;
      nrpOut   <= '0;
      uspOut   <= '0;
      spOut    <= '0;
      ccsOut   <= '0;
      exsOut   <= '0;
      dslotClr <= 1'b0;
    end else begin
      dslotClr <= 1'b0;
      if (strobe.capture) begin
        vecReg   <= vecSel;
        baseReg  <= ebpIn;
        ccsOut   <= ccsRot;
        exsOut   <= {{EXS_HI{1'b0}}, vecSel, {EXS_LO{1'b0}}};
        dslotClr <= (dslotCnt != '0);
        if (isNmi) nrpOut <= retAddr;
        else       erpOut <= retAddr;
        if (userMode) begin
          uspOut <= spIn;
          spOut  <= kspIn;
        end else begin
          spOut  <= spIn;
        end
      end
      if (strobe.loadPc) pcOut <= memRdata;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evBreak,
  input  logic             evNmi,
  input  logic             evBusFault,
  input  logic             evIrq,
  input  logic [VEC_W-1:0] irqVec,
  input  logic [VEC_W-1:0] trapVec,
  input  logic [VEC_W-1:0] faultVec,
  input  logic             irqLock,
  input  logic [XLEN-1:0]  pcIn,
  input  logic [DS_W-1:0]  dslotCnt,
  input  logic [XLEN-1:0]  ccsIn,
  input  logic [VER_W-1:0] archVer,
  input  logic [XLEN-1:0]  spIn,
  input  logic [XLEN-1:0]  kspIn,
  input  logic [XLEN-1:0]  ebpIn,
  input  logic [XLEN-1:0]  memRdata,
  input  logic             memRvalid,
  output logic             memReq,
  output logic [XLEN-1:0]  memAddr,
  output logic             busy,
  output logic             pcLoad,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  erpOut,
  output logic [XLEN-1:0]  nrpOut,
  output logic [XLEN-1:0]  uspOut,
  output logic [XLEN-1:0]  spOut,
  output logic [XLEN-1:0]  ccsOut,
  output logic [XLEN-1:0]  exsOut,
  output logic             dslotClr,
  output logic             fatalErr
);
  seqStrobe_t strobe;
  logic       iFlag, mFlag;

  exc_entry_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .evBreak(evBreak), .evNmi(evNmi), .evBusFault(evBusFault), .evIrq(evIrq),
    .irqLock(irqLock), .iFlag(iFlag), .mFlag(mFlag), .memRvalid(memRvalid),
    .strobe(strobe), .busy(busy), .memReq(memReq), .pcLoad(pcLoad),
    .fatalErr(fatalErr)
  );

  exc_entry_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .irqVec(irqVec), .trapVec(trapVec), .faultVec(faultVec),
    .pcIn(pcIn), .dslotCnt(dslotCnt), .ccsIn(ccsIn), .archVer(archVer),
    .spIn(spIn), .kspIn(kspIn), .ebpIn(ebpIn), .memRdata(memRdata),
    .iFlag(iFlag), .mFlag(mFlag), .memAddr(memAddr), .pcOut(pcOut),
    .erpOut(erpOut), .nrpOut(nrpOut), .uspOut(uspOut), .spOut(spOut),
    .ccsOut(ccsOut), .exsOut(exsOut), .dslotClr(dslotClr)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memRvalid,
  input logic [31:0] memAddr,
  input logic        busy,
  input logic        pcLoad,
  input logic [31:0] ccsOut,
  input logic [31:0] exsOut,
  input logic        fatalErr,
  input logic        evNmi,
  input logic        evBusFault,
  input logic        evBreak,
  input logic        evIrq
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRvalid) |=> ((memReq && $stable(memAddr)) || fatalErr)); // R9
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr |=> (fatalErr && busy && !memReq && !pcLoad)); // R11
  AST_CCS_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (ccsOut[9:0] == 10'd0)); // R8
  AST_EXS_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (exsOut[31:16] == 16'd0 && exsOut[7:0] == 8'd0)); // R5
  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !evNmi && !evBusFault && !evBreak && !evIrq) |=> !busy); // R1
endmodule

bind exc_entry_seq exc_entry_chk chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memRvalid(memRvalid),
  .memAddr(memAddr), .busy(busy), .pcLoad(pcLoad), .ccsOut(ccsOut),
  .exsOut(exsOut), .fatalErr(fatalErr), .evNmi(evNmi),
  .evBusFault(evBusFault), .evBreak(evBreak), .evIrq(evIrq)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0;
  logic evBreak = 0, evNmi = 0, evBusFault = 0, evIrq = 0, irqLock = 0;
  logic [7:0]  irqVec = 0, trapVec = 0, faultVec = 0, archVer = 0;
  logic [1:0]  dslotCnt = 0;
  logic [31:0] pcIn = 0, ccsIn = 0, spIn = 0, kspIn = 0, ebpIn = 0;
  logic [31:0] memRdata = 0;
  logic        memRvalid = 0;
  logic        memReq, busy, pcLoad, dslotClr, fatalErr;
  logic [31:0] memAddr, pcOut, erpOut, nrpOut, uspOut, spOut, ccsOut, exsOut;

  int checks = 0, failures = 0, cycles = 0, lat = 0, waitCnt = 0;
  logic [31:0] eErp = 0, eNrp = 0, eUsp = 0;

  exc_entry_seq dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] tableWord(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  function automatic logic [31:0] rotCcs(input logic [31:0] c);
    return ((c & 32'hC000_0000) | ((c << 12) >> 2)) & ~32'h3FF;
  endfunction

  always @(negedge clk) begin
    if (memReq && !memRvalid) begin
      if (waitCnt >= lat) begin
        memRvalid <= 1'b1;
        memRdata  <= tableWord(memAddr);
      end else waitCnt <= waitCnt + 1;
    end else begin
      memRvalid <= 1'b0;
      waitCnt   <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    eErp = 0; eNrp = 0; eUsp = 0;
    @(negedge clk);
  endtask

  // kind: 0 break, 1 nmi, 2 bus fault, 3 irq
  task automatic run_entry(input int kind, input logic [31:0] ccs, input logic [7:0] ver,
                           input logic [1:0] ds, input logic [7:0] vec, input int latency);
    logic [31:0] ra, eCcs, eSp, eAddr;
    logic [7:0]  v;
    int n;
    lat = latency;
    pcIn = 32'h4000_0100 + {vec, 4'h0} + 32'(ds) * 32'h111;
    spIn = 32'h7FFF_0000 ^ {24'd0, vec};
    kspIn = 32'h8000_F000 + 32'(vec);
    ebpIn = 32'h0010_0000 + {vec, 12'h0};
    ccsIn = ccs; archVer = ver; dslotCnt = ds; irqLock = 0;
    trapVec = vec; faultVec = vec ^ 8'h5A; irqVec = ~vec;
    v = (kind == 0) ? trapVec : (kind == 1) ? 8'd0 : (kind == 2) ? faultVec : irqVec;
    evBreak = (kind == 0); evNmi = (kind == 1); evBusFault = (kind == 2); evIrq = (kind == 3);
    ra = pcIn - 32'(ds);
    eCcs = ccs;
    if (kind == 1) eCcs[(ver < 8'd32) ? 9 : 30] = 1'b0;
    eCcs = rotCcs(eCcs);
    if (kind == 1) eNrp = ra; else eErp = ra;
    if (ccs[8]) begin eUsp = spIn; eSp = kspIn; end else eSp = spIn;
    eAddr = ebpIn + 32'(v) * 4;
    @(negedge clk);
    evBreak = 0; evNmi = 0; evBusFault = 0; evIrq = 0;
    chk(busy === 1'b1, "R9 busy after accept", {31'd0, busy}, 1);
    chk(dslotClr === (ds != 0), "R6 dslotClr", {31'd0, dslotClr}, {31'd0, ds != 0});
    chk(memReq === 1'b1 && memAddr === eAddr, "R9 memAddr", memAddr, eAddr);
    n = 0;
    while (pcLoad !== 1'b1 && n < 60) begin @(negedge clk); n++; end
    chk(pcOut === tableWord(eAddr), "R9 pcOut", pcOut, tableWord(eAddr));
    chk(erpOut === eErp, "R4 R6 erpOut", erpOut, eErp);
    chk(nrpOut === eNrp, "R4 R6 nrpOut", nrpOut, eNrp);
    chk(exsOut === {16'd0, v, 8'd0}, "R5 exsOut", exsOut, {16'd0, v, 8'd0});
    chk(ccsOut === eCcs, "R8 ccsOut", ccsOut, eCcs);
    chk(spOut === eSp && uspOut === eUsp, "R7 stacks", spOut, eSp);
    @(negedge clk);
    chk(busy === 1'b0 && pcLoad === 1'b0, "R9 return idle", {31'd0, busy}, 0);
  endtask

  task automatic expect_ignored(input string req);
    logic [31:0] oldErp, oldNrp;
    oldErp = erpOut; oldNrp = nrpOut;
    @(negedge clk);
    evBreak = 0; evNmi = 0; evBusFault = 0; evIrq = 0;
    chk(busy === 1'b0 && erpOut === oldErp && nrpOut === oldNrp, req, {31'd0, busy}, 0);
  endtask

  initial begin
    do_reset();
    // R12 reset state
    chk(busy === 0 && memReq === 0 && pcLoad === 0 && dslotClr === 0 && fatalErr === 0,
        "R12 reset ctrl", {27'd0, busy, memReq, pcLoad, dslotClr, fatalErr}, 0);
    chk((pcOut | erpOut | nrpOut | uspOut | spOut | ccsOut | exsOut) === 32'd0,
        "R12 reset regs", pcOut | erpOut | nrpOut | ccsOut, 0);

    // Sweep: kind x user mode x delay slot x version
    for (int k = 0; k < 4; k++)
      for (int u = 0; u < 2; u++)
        for (int d = 0; d < 4; d++)
          for (int vr = 0; vr < 2; vr++) begin
            logic [31:0] c;
            c = 32'h9E37_79B9 * 32'(k * 16 + u * 8 + d * 2 + vr + 1);
            c[8] = u[0]; c[4] = 1'b1; c[9] = 1'b1; c[30] = 1'b1;
            run_entry(k, c, vr ? 8'd32 : 8'd31, d[1:0], 8'(k * 37 + d * 11 + u * 5 + vr), (k + d) % 4);
          end

    // Every external interrupt vector
    for (int v = 0; v < 256; v++) begin
      logic [31:0] c;
      c = 32'hC0FF_EE00 ^ (32'(v) * 32'h0101_0101);
      c[4] = 1'b1;
      run_entry(3, c, 8'(v), 2'(v), 8'(v), v % 3);
    end

    // R1 masking: I clear, then lock set
    ccsIn = 32'h0000_0000; irqLock = 0; evIrq = 1; expect_ignored("R1 irq masked by I");
    ccsIn = 32'h0000_0010; irqLock = 1; evIrq = 1; expect_ignored("R1 irq masked by lock");
    irqLock = 0;

    // R2 NMI enable by version: old arch uses bit 9, new uses bit 30
    ccsIn = 32'h4000_0000; archVer = 8'd5;  evNmi = 1; expect_ignored("R2 nmi old arch bit9 clear");
    ccsIn = 32'h0000_0200; archVer = 8'd40; evNmi = 1; expect_ignored("R2 nmi new arch bit30 clear");
    run_entry(1, 32'h0000_0200, 8'd31, 2'd0, 8'd9, 1);
    chk(ccsOut[19] === 1'b0, "R2 R8 old M cleared", {31'd0, ccsOut[19]}, 0);
    run_entry(1, 32'h4000_0000, 8'd200, 2'd1, 8'd9, 0);
    chk(ccsOut[30] === 1'b0, "R2 R8 new M cleared", {31'd0, ccsOut[30]}, 0);

    // R3 priority: NMI over all, bus fault over break and irq, break over irq
    begin
      logic [31:0] oldErp;
      ccsIn = 32'h4000_0010; archVer = 8'd50; pcIn = 32'h0000_2000; dslotCnt = 0;
      trapVec = 8'h11; faultVec = 8'h22; irqVec = 8'h33; ebpIn = 32'h0; lat = 0;
      oldErp = erpOut;
      evNmi = 1; evBusFault = 1; evBreak = 1; evIrq = 1;
      @(negedge clk); evNmi = 0; evBusFault = 0; evBreak = 0; evIrq = 0;
      chk(exsOut === 32'h0 && nrpOut === 32'h2000 && erpOut === oldErp, "R3 nmi first", exsOut, 0);
      while (busy) @(negedge clk);
      evBusFault = 1; evBreak = 1; evIrq = 1;
      @(negedge clk); evBusFault = 0; evBreak = 0; evIrq = 0;
      chk(exsOut === 32'h2200, "R3 bus fault over break", exsOut, 32'h2200);
      while (busy) @(negedge clk);
      evBreak = 1; evIrq = 1;
      @(negedge clk); evBreak = 0; evIrq = 0;
      chk(exsOut === 32'h1100, "R3 break over irq", exsOut, 32'h1100);
      while (busy) @(negedge clk);
    end

    // R10 requests during an entry are ignored
    begin
      logic [31:0] firstPc;
      lat = 5; pcIn = 32'h0000_5550; firstPc = pcIn; dslotCnt = 0; ccsIn = 32'h10;
      trapVec = 8'h07; evBreak = 1;
      @(negedge clk); evBreak = 0;
      pcIn = 32'h0000_9990; trapVec = 8'h44; evBreak = 1; evIrq = 1;
      @(negedge clk); evBreak = 0; evIrq = 0;
      while (busy) @(negedge clk);
      chk(erpOut === firstPc && exsOut === 32'h0700, "R10 busy ignores requests", erpOut, firstPc);
      @(negedge clk);
      chk(busy === 1'b0, "R10 no queued entry", {31'd0, busy}, 0);
    end

    // R11 recursive bus fault
    lat = 8; faultVec = 8'h0C; evBusFault = 1;
    @(negedge clk); evBusFault = 0;
    @(negedge clk); evBusFault = 1;
    @(negedge clk); evBusFault = 0;
    chk(fatalErr === 1'b1 && busy === 1'b1 && memReq === 1'b0, "R11 fatal set",
        {29'd0, fatalErr, busy, memReq}, 32'b110);
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (pcLoad) seen++;
        if (i == 3) evBreak = 1;
        if (i == 4) evBreak = 0;
      end
      chk(fatalErr === 1'b1 && seen == 0, "R11 fatal sticky", {31'd0, fatalErr}, 1);
    end
    do_reset();
    chk(fatalErr === 1'b0 && busy === 1'b0, "R12 reset clears fatal", {31'd0, fatalErr}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule